// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block is the control core of a device programmer for UV-erasable EPROMs. After one start request it copies a contiguous range of bytes from a source buffer into the target device. It works in three passes. The first is a blind pass that gives each location exactly one program pulse. The second is an interactive pass that repeats pulse-then-verify on each byte, up to a fixed limit. The last is a closing comparison of the whole range with the supplies dropped back to their nominal level.

The sequencer drives the device address, the byte to be written with its drive enable, an active-low chip enable and an active-low output enable. It also drives one digital select that asks the supply circuitry for the elevated programming voltages instead of the nominal ones. Source bytes come from a synchronous buffer port with a fixed one-cycle read latency. Device bytes are read back on a separate input while output enable is low. When the run ends, the block reports pass or fail and, on failure, the address that failed. The program pulse length is a clock-count parameter.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset and while idle, `busy_o`, `pass_o`, `fail_o`, `hv_sel_o` and `dev_wdata_oe_o` are 0, and both `ce_n_o` and `oe_n_o` are 1.
- R2: A start request taken while idle raises `busy_o` and `hv_sel_o` on the next cycle and clears `pass_o` and `fail_o`. `hv_sel_o` stays 1 through the blind and interactive passes. A start request made while `busy_o` is 1 has no effect on the run.
- R3: The blind pass gives exactly one program pulse to each address from `first_addr_i` up to `last_addr_i`, in ascending order. The byte written to an address is the buffer word read at that same address, which appears on `src_data_i` one cycle after `src_addr_o`.
- R4: Each program pulse holds `ce_n_o` low for exactly PULSE_CYCLES cycles with `oe_n_o` high. Address and data are driven at least one cycle before the pulse and at least one cycle after it, and both stay unchanged during the pulse.
- R5: The interactive pass starts again at the first address. Every pulse in this pass is followed by a verify read, with `oe_n_o` low, `ce_n_o` high and data not driven. A read that matches the written byte moves the pass to the next address.
- R6: In the interactive pass a byte gets at most 10 pulses. If the verify after the tenth pulse still does not match, the run stops with `fail_o` set and `fail_addr_o` holding that address, and no final comparison takes place.
- R7: After the last address verifies, `hv_sel_o` drops to 0. Each address in the range is then read in ascending order with `ce_n_o` and `oe_n_o` both low and compared with the buffer. The first mismatch ends the run with `fail_o` and `fail_addr_o` set. If every address matches, `pass_o` is set.
- R8: `pass_o` and `fail_o` are never both 1. Once a run has ended they keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| first_addr_i | input | AW | First device address of the range |
| last_addr_i | input | AW | Last device address of the range |
| src_addr_o | output | AW | Source buffer read address |
| src_data_i | input | DW | Source buffer data, one cycle after its address |
| dev_addr_o | output | AW | Device address |
| dev_wdata_o | output | DW | Byte driven toward the device |
| dev_wdata_oe_o | output | 1 | Drive enable for dev_wdata_o |
| dev_rdata_i | input | DW | Byte read back from the device |
| ce_n_o | output | 1 | Active-low chip enable (program pulse or read) |
| oe_n_o | output | 1 | Active-low output enable |
| hv_sel_o | output | 1 | 1 selects the elevated programming supplies, 0 the nominal ones |
| busy_o | output | 1 | Run in progress |
| pass_o | output | 1 | Last run completed with every byte matching |
| fail_o | output | 1 | Last run ended in failure |
| fail_addr_o | output | AW | Address of the failure |

## Verification
A wrong pass state or a wrong address shows up on the device pins right away, within the pulse where it happens. The pulse lands on an unexpected address, a pulse is extra or missing, or the pulse is off by a cycle. The bench device model counts each of these against the value computed from the range. A retry count that is off by one does not show in a single byte's pins; it only appears as a different total pulse count, or as a pass that should have been a fail, when the run ends. The bench therefore drives bytes that need exactly ten and exactly eleven interactive pulses. A broken nominal-supply comparison can only show at the end of the run, so one case has a cell that reads back correctly only while the elevated supplies are selected.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_VACC,
        ST_VCMP,
        ST_RACC,
        ST_RCMP
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_BLIND,
        PH_ITER,
        PH_FINAL
    } seq_phase_e;

endpackage

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer #(
    parameter int PULSE_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = LOAD_VAL;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/eprom_retry_ctr.sv
module eprom_retry_ctr #(
    parameter int MAX_TRIES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic limit_o
);
    localparam int RW = $clog2(MAX_TRIES + 1);

    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i && cnt_q != RW'(MAX_TRIES))
            cnt_d = cnt_q + RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign limit_o = (cnt_q == RW'(MAX_TRIES));
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_seq_pkg::*;
#(
    parameter int AW           = 15,
    parameter int DW           = 8,
    parameter int PULSE_CYCLES = 10000,
    parameter int MAX_TRIES    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] first_addr_i,
    input  logic [AW-1:0] last_addr_i,
    output logic [AW-1:0] src_addr_o,
    input  logic [DW-1:0] src_data_i,
    output logic [AW-1:0] dev_addr_o,
    output logic [DW-1:0] dev_wdata_o,
    output logic          dev_wdata_oe_o,
    input  logic [DW-1:0] dev_rdata_i,
    output logic          ce_n_o,
    output logic          oe_n_o,
    output logic          hv_sel_o,
    output logic          busy_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o
);
    typedef struct packed {
        seq_state_e    state;
        seq_phase_e    phase;
        logic [AW-1:0] first;
        logic [AW-1:0] last;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          pass;
        logic          fail;
        logic [AW-1:0] fail_addr;
    } seq_t;

    seq_t q, d;

    logic tmr_load, tmr_done;
    logic rty_clr, rty_inc, rty_limit;
    logic byte_match, at_last;

    eprom_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .done_o (tmr_done)
    );

    eprom_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rty_clr),
        .inc_i   (rty_inc),
        .limit_o (rty_limit)
    );

    assign byte_match = (dev_rdata_i == q.data);
    assign at_last    = (q.addr == q.last);

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        rty_clr  = 1'b0;
        rty_inc  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.first = first_addr_i;
                    d.last  = last_addr_i;
                    d.addr  = first_addr_i;
                    d.phase = PH_BLIND;
                    d.pass  = 1'b0;
                    d.fail  = 1'b0;
                    d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                rty_clr = (q.phase == PH_ITER);
                d.state = ST_LOAD;
            end
            ST_LOAD: begin
                d.data  = src_data_i;
                d.state = (q.phase == PH_FINAL) ? ST_RACC : ST_SETUP;
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                d.state  = ST_PULSE;
            end
            ST_PULSE: begin
                if (tmr_done) d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (q.phase == PH_BLIND) begin
                    if (at_last) begin
                        d.phase = PH_ITER;
                        d.addr  = q.first;
                    end else begin
                        d.addr  = q.addr + AW'(1);
                    end
                    d.state = ST_FETCH;
                end else begin
                    rty_inc = 1'b1;
                    d.state = ST_VACC;
                end
            end
            ST_VACC: d.state = ST_VCMP;
            ST_VCMP: begin
                if (byte_match) begin
                    if (at_last) begin
                        d.phase = PH_FINAL;
                        d.addr  = q.first;
                    end else begin
                        d.addr  = q.addr + AW'(1);
                    end
                    d.state = ST_FETCH;
                end else if (rty_limit) begin
                    d.fail      = 1'b1;
                    d.fail_addr = q.addr;
                    d.state     = ST_IDLE;
                end else begin
                    d.state = ST_SETUP;
                end
            end
            ST_RACC: d.state = ST_RCMP;
            ST_RCMP: begin
                if (!byte_match) begin
                    d.fail      = 1'b1;
                    d.fail_addr = q.addr;
                    d.state     = ST_IDLE;
                end else if (at_last) begin
                    d.pass  = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.addr  = q.addr + AW'(1);
                    d.state = ST_FETCH;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_IDLE;
            q.phase     <= PH_BLIND;
            q.first     <= '0;
            q.last      <= '0;
            q.addr      <= '0;
            q.data      <= '0;
            q.pass      <= 1'b0;
            q.fail      <= 1'b0;
            q.fail_addr <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o         = (q.state != ST_IDLE);
    assign hv_sel_o       = busy_o && (q.phase != PH_FINAL);
    assign src_addr_o     = q.addr;
    assign dev_addr_o     = q.addr;
    assign dev_wdata_o    = q.data;
    assign dev_wdata_oe_o = (q.state == ST_SETUP) || (q.state == ST_PULSE) ||
                            (q.state == ST_HOLD);
    assign ce_n_o         = !((q.state == ST_PULSE) || (q.state == ST_RACC) ||
                              (q.state == ST_RCMP));
    assign oe_n_o         = !((q.state == ST_VACC) || (q.state == ST_VCMP) ||
                              (q.state == ST_RACC) || (q.state == ST_RCMP));
    assign pass_o         = q.pass;
    assign fail_o         = q.fail;
    assign fail_addr_o    = q.fail_addr;
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
    parameter int AW           = 15,
    parameter int DW           = 8,
    parameter int PULSE_CYCLES = 10000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          pass_o,
    input logic          fail_o,
    input logic          ce_n_o,
    input logic          oe_n_o,
    input logic          hv_sel_o,
    input logic [AW-1:0] dev_addr_o,
    input logic [DW-1:0] dev_wdata_o,
    input logic          dev_wdata_oe_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 2);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             low_cnt_q <= '0;
        else if (!ce_n_o && hv_sel_o && oe_n_o) low_cnt_q <= low_cnt_q + CW'(1);
        else                                    low_cnt_q <= '0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ce_n_o && oe_n_o && !dev_wdata_oe_o && !hv_sel_o));

    assert_start_hv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && hv_sel_o && !pass_o && !fail_o));

    assert_pulse_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_o && hv_sel_o) |-> (oe_n_o && dev_wdata_oe_o));

    assert_pulse_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ce_n_o) && hv_sel_o) |-> $past(dev_wdata_oe_o));

    assert_pulse_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce_n_o) && hv_sel_o) |->
            (dev_wdata_oe_o && $stable(dev_addr_o) && $stable(dev_wdata_o)));

    assert_pulse_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_o && $past(!ce_n_o) && hv_sel_o) |->
            ($stable(dev_addr_o) && $stable(dev_wdata_o)));

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n_o && low_cnt_q != '0) |-> (low_cnt_q == CW'(PULSE_CYCLES)));

    assert_verify_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_o && hv_sel_o) |-> (ce_n_o && !dev_wdata_oe_o));

    assert_final_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_o && !hv_sel_o) |-> (!ce_n_o && !dev_wdata_oe_o));

    assert_fail_ends_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> !busy_o);

    assert_status_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));

    assert_status_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o)));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
    .AW(AW), .DW(DW), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .busy_o         (busy_o),
    .pass_o         (pass_o),
    .fail_o         (fail_o),
    .ce_n_o         (ce_n_o),
    .oe_n_o         (oe_n_o),
    .hv_sel_o       (hv_sel_o),
    .dev_addr_o     (dev_addr_o),
    .dev_wdata_o    (dev_wdata_o),
    .dev_wdata_oe_o (dev_wdata_oe_o)
);

// File: tb/eprom_prog_seq_bench.sv
module eprom_prog_seq_bench;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int PC = 6;
    localparam int TRIES = 10;

    typedef struct packed {
        logic [7:0] first;
        logic [7:0] last;
        logic [7:0] base_need;
        logic [7:0] spec_addr;
        logic [7:0] spec_need;
        logic       weak_en;
        logic [7:0] weak_addr;
    } row_t;

    localparam row_t TABLE [6] = '{
        '{8'h10, 8'h13, 8'd1, 8'h00, 8'd1,  1'b0, 8'h00},
        '{8'h20, 8'h27, 8'd3, 8'h22, 8'd11, 1'b0, 8'h00},
        '{8'h30, 8'h35, 8'd2, 8'h33, 8'd12, 1'b0, 8'h00},
        '{8'h40, 8'h44, 8'd1, 8'h00, 8'd1,  1'b1, 8'h42},
        '{8'h7F, 8'h7F, 8'd5, 8'h00, 8'd5,  1'b0, 8'h00},
        '{8'h00, 8'h02, 8'd1, 8'h00, 8'd12, 1'b0, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic [AW-1:0] src_addr, dev_addr, fail_addr;
    logic [DW-1:0] src_data = '0, dev_wdata, dev_rdata;
    logic          wdata_oe, ce_n, oe_n, hv_sel, busy, pass, fail;

    always #5 clk = ~clk;

    eprom_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYCLES(PC), .MAX_TRIES(TRIES)) u_eprom_prog_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .first_addr_i(first_addr), .last_addr_i(last_addr),
        .src_addr_o(src_addr), .src_data_i(src_data),
        .dev_addr_o(dev_addr), .dev_wdata_o(dev_wdata), .dev_wdata_oe_o(wdata_oe),
        .dev_rdata_i(dev_rdata), .ce_n_o(ce_n), .oe_n_o(oe_n), .hv_sel_o(hv_sel),
        .busy_o(busy), .pass_o(pass), .fail_o(fail), .fail_addr_o(fail_addr)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    row_t cur;
    logic erase_req = 1'b0;
    logic [7:0] mem  [256];
    logic [7:0] pcnt [256];
    int run_len = 0, pulses = 0, width_err = 0, order_err = 0, vfy = 0, fin = 0;
    logic oe_prev = 1'b1;

    function automatic logic [7:0] srcval(input logic [7:0] a);
        return 8'((int'(a) * 7 + 3) & 8'h7F);
    endfunction

    function automatic int need(input logic [7:0] a);
        return (a == cur.spec_addr) ? int'(cur.spec_need) : int'(cur.base_need);
    endfunction

    always @(posedge clk) src_data <= srcval(src_addr);

    assign dev_rdata = oe_n ? 8'h00 :
        ((cur.weak_en && !hv_sel && dev_addr == cur.weak_addr) ? (mem[dev_addr] ^ 8'h01)
                                                              : mem[dev_addr]);

    // Device model: counts pulses, applies programming after enough pulses.
    always @(posedge clk) begin
        if (erase_req) begin
            for (int i = 0; i < 256; i++) begin
                mem[i]  = 8'hFF;
                pcnt[i] = 8'd0;
            end
            run_len = 0; pulses = 0; width_err = 0; order_err = 0; vfy = 0; fin = 0;
            oe_prev = 1'b1;
        end else begin
            if (!ce_n && oe_n && hv_sel) begin
                run_len++;
            end else if (run_len != 0) begin
                if (run_len != PC) width_err++;
                if (pulses <= int'(cur.last - cur.first) &&
                    dev_addr != 8'(int'(cur.first) + pulses)) order_err++;
                pcnt[dev_addr] = pcnt[dev_addr] + 8'd1;
                if (int'(pcnt[dev_addr]) >= need(dev_addr))
                    mem[dev_addr] = mem[dev_addr] & dev_wdata;
                pulses++;
                run_len = 0;
            end
            if (!oe_n && oe_prev) begin
                if (hv_sel) vfy++;
                else        fin++;
            end
            oe_prev = oe_n;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_row(input row_t r, input bit poke);
        int n, exp_pulses, exp_vfy, exp_fin, exp_faddr, mem_bad;
        bit exp_fail;
        n = int'(r.last) - int'(r.first) + 1;
        exp_pulses = n; exp_vfy = 0; exp_fin = 0; exp_fail = 0; exp_faddr = 0;
        @(negedge clk);
        cur = r;
        first_addr = r.first;
        last_addr  = r.last;
        for (int a = int'(r.first); a <= int'(r.last); a++) begin
            int k, p2;
            k  = need(8'(a));
            p2 = (k <= 1) ? 1 : k - 1;
            if (p2 > TRIES) begin
                exp_pulses += TRIES; exp_vfy += TRIES;
                exp_fail = 1; exp_faddr = a;
                break;
            end
            exp_pulses += p2; exp_vfy += p2;
        end
        if (!exp_fail) begin
            if (r.weak_en && r.weak_addr >= r.first && r.weak_addr <= r.last) begin
                exp_fin = int'(r.weak_addr) - int'(r.first) + 1;
                exp_fail = 1; exp_faddr = int'(r.weak_addr);
            end else begin
                exp_fin = n;
            end
        end
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && hv_sel && !pass && !fail, "R2", "start raises busy and elevated supply",
              {busy, hv_sel, pass, fail}, 4'b1100);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1; first_addr = 8'h90; last_addr = 8'h91;
            @(negedge clk);
            start = 1'b0;
            repeat (37) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        check(fail == exp_fail, exp_fail ? "R6" : "R7", "fail flag", fail, exp_fail);
        check(pass == !exp_fail, "R7", "pass flag", pass, !exp_fail);
        if (exp_fail)
            check(fail_addr == 8'(exp_faddr), "R6", "failing address", fail_addr, exp_faddr);
        check(pulses == exp_pulses, poke ? "R2" : "R3", "total pulse count", pulses, exp_pulses);
        check(order_err == 0, "R3", "blind pass address order errors", order_err, 0);
        check(width_err == 0, "R4", "pulse width errors", width_err, 0);
        check(vfy == exp_vfy, "R5", "verify read count", vfy, exp_vfy);
        check(fin == exp_fin, "R7", "final read count", fin, exp_fin);
        if (!exp_fail) begin
            mem_bad = 0;
            for (int a = int'(r.first); a <= int'(r.last); a++)
                if (mem[a] != srcval(8'(a))) mem_bad++;
            check(mem_bad == 0, "R3", "bytes differing from source", mem_bad, 0);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cur = TABLE[0];
        repeat (4) @(negedge clk);
        // R1: reset and idle state
        check(!busy && !pass && !fail && !hv_sel && !wdata_oe && ce_n && oe_n,
              "R1", "idle outputs", {busy, pass, fail, hv_sel, wdata_oe, ce_n, oe_n}, 7'b0000011);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && ce_n && oe_n && !hv_sel, "R1", "idle after reset release",
              {busy, ce_n, oe_n, hv_sel}, 4'b0110);

        for (int i = 0; i < 6; i++) run_row(TABLE[i], i == 1);

        // R8: status held after a passing run, then cleared by a new start
        run_row(TABLE[0], 1'b0);
        repeat (5) @(negedge clk);
        check(pass && !fail, "R8", "pass held while idle", {pass, fail}, 2'b10);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!pass && !fail && busy, "R8", "status cleared by start", {pass, fail, busy}, 3'b001);
        while (busy) @(negedge clk);
        check(pass, "R8", "second run passes", pass, 1);

        // R6: failure status held
        run_row(TABLE[2], 1'b0);
        repeat (5) @(negedge clk);
        check(fail && !pass && fail_addr == 8'h33, "R8", "fail held while idle",
              {fail, pass}, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule